// File: doc/BRIEF.md
# Product-Term Programmable Macrocell

This block is one cell of a programmable logic fabric. A set of input signals, each available both true and inverted, feeds ten programmable AND terms. Eight of them are ORed into a sum. The sum can be inverted and then either drives the pin directly or passes through a single flip-flop. One term is kept as an asynchronous clear. One more term is used as a local clock or as an output enable.

All personality is a static parallel configuration vector `cfg_i`. The flip-flop can act as a D or a T register and can trigger on either clock edge. Its clock is either the global clock or the local product-term clock. A feedback port returns either the register state or the observed pad level to the surrounding array.

Top module: `pt_macrocell`

## Requirements
- R1: Term t (0..9) uses fuse bits `cfg_i[t*2*N_IN +: 2*N_IN]`. Within a term, bit 2k connects input k true and bit 2k+1 connects input k inverted. A term is the AND of its connected literals, and it evaluates to 0 when no literal is connected.
- R2: The sum is the OR of terms 0 to 7. With `cfg_i[FUSE_W+4]`=1 (FUSE_W = 20*N_IN), `out_o` follows the polarity-adjusted sum combinationally. With that bit at 0, `out_o` shows the register.
- R3: With `cfg_i[FUSE_W+0]`=1 the sum is inverted before both the register and the combinational output.
- R4: In D mode (`cfg_i[FUSE_W+1]`=0), global-clock mode and rising-edge mode, the register loads the polarity-adjusted sum on each rising edge of `clk_i`. Between edges it holds.
- R5: With `cfg_i[FUSE_W+2]`=1 the register triggers on the falling edge of its selected clock instead of the rising edge.
- R6: In T mode (`cfg_i[FUSE_W+1]`=1) the register inverts its state on an active edge when the polarity-adjusted sum is 1, and holds its state when the sum is 0.
- R7: While term 8 is 1 the register is cleared to 0 at once. No clock edge is needed, and the clear wins over any edge.
- R8: With `cfg_i[FUSE_W+3]`=1 (local clock mode) the register is clocked by term 9 and `clk_i` has no effect. `oe_o` is held at 1.
- R9: With `cfg_i[FUSE_W+3]`=0, `oe_o` equals term 9.
- R10: With `cfg_i[FUSE_W+5]`=0, `fb_o` returns the register state. With that bit at 1, `fb_o` returns `pad_i`.
- R11: While `rst_ni` is 0 the register is 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the register |
| in_i | input | N_IN | Input signals to the AND array |
| cfg_i | input | 20*N_IN+6 | Static configuration: fuses, then six control bits |
| pad_i | input | 1 | Observed pad level, used for pin feedback |
| out_o | output | 1 | Value driven toward the pin |
| oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Feedback value returned to the array |

## Verification
The bench builds the cell with N_IN = 4. This gives eight literals per term, so each term's fuses fit in one byte. With that width a single configuration can place a literal and its complement in the same term, leave terms blank, or use only the eighth sum term. The same setting is wide enough to give the clear term and the local clock or enable term their own inputs. The clear input and the local-clock input can therefore be switched without disturbing the sum. That lets the bench separate an asynchronous clear, a local-clock edge and a global edge from one another.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int N_SUM   = 8;   // terms ORed into the sum
  localparam int N_PT    = 10;  // sum terms + clear + local clock/oe
  localparam int PT_CLR  = 8;
  localparam int PT_LCLK = 9;
  localparam int CTL_W   = 6;
  // control bit offsets above the fuse field
  localparam int C_INV   = 0;
  localparam int C_TFF   = 1;
  localparam int C_NEG   = 2;
  localparam int C_ASYNC = 3;
  localparam int C_COMB  = 4;
  localparam int C_FBPIN = 5;
endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 10,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]          in_i,
  input  logic [N_TERM*LIT_W-1:0]  fuse_i,
  output logic [N_TERM-1:0]        term_o
);
  logic [LIT_W-1:0] lit;

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit[2*k]   = in_i[k];
    assign lit[2*k+1] = ~in_i[k];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] f;
    assign f         = fuse_i[t*LIT_W +: LIT_W];
    // blank term reads 0 so unused clear/oe terms stay inert
    assign term_o[t] = (|f) & (&(~f | lit));
  end
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic clk_i,
  input  logic lclk_i,
  input  logic async_i,
  input  logic neg_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tff_i,
  input  logic d_i,
  output logic q_o
);
  logic clk_mux, clk_eff, arst;

  assign clk_mux = async_i ? lclk_i : clk_i;
  assign clk_eff = clk_mux ^ neg_i;
  assign arst    = ~rst_ni | clr_i;

  always_ff @(posedge clk_eff or posedge arst) begin
    if (arst)       q_o <= 1'b0;
    else if (tff_i) q_o <= q_o ^ d_i;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN    = 4,
  localparam int LIT_W  = 2 * N_IN,
  localparam int FUSE_W = N_PT * LIT_W,
  localparam int CFG_W  = FUSE_W + CTL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pad_i,
  output logic             out_o,
  output logic             oe_o,
  output logic             fb_o
);
  logic [N_PT-1:0]  term;
  logic [CTL_W-1:0] ctl;
  logic             sum, f_val, q, pt_clr, pt_lclk;

  assign ctl = cfg_i[FUSE_W +: CTL_W];

  mc_pterm_array #(.N_IN(N_IN), .N_TERM(N_PT)) u_arr (
    .in_i   (in_i),
    .fuse_i (cfg_i[FUSE_W-1:0]),
    .term_o (term)
  );

  assign sum     = |term[N_SUM-1:0];
  assign f_val   = sum ^ ctl[C_INV];
  assign pt_clr  = term[PT_CLR];
  assign pt_lclk = term[PT_LCLK];

  mc_reg u_reg (
    .clk_i   (clk_i),
    .lclk_i  (pt_lclk),
    .async_i (ctl[C_ASYNC]),
    .neg_i   (ctl[C_NEG]),
    .rst_ni  (rst_ni),
    .clr_i   (pt_clr),
    .tff_i   (ctl[C_TFF]),
    .d_i     (f_val),
    .q_o     (q)
  );

  assign out_o = ctl[C_COMB]  ? f_val : q;
  assign oe_o  = ctl[C_ASYNC] ? 1'b1  : pt_lclk;
  assign fb_o  = ctl[C_FBPIN] ? pad_i : q;
endmodule

// File: rtl/mc_chk.sv
module mc_chk #(
  parameter int CFG_W = 86
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] cfg_i,
  input logic             q,
  input logic             f_val,
  input logic             clr,
  input logic             async_m,
  input logic             neg_m,
  input logic             tff_m,
  input logic             comb_m,
  input logic             fbpin_m,
  input logic             out_o,
  input logic             oe_o,
  input logic             fb_o
);
  // R8
  lclk_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_m |-> oe_o);

  // R4
  dload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_m && !neg_m && !tff_m && !clr) |=>
      ($changed(cfg_i) || clr || q == $past(f_val)));

  // R6
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_m && !neg_m && tff_m && !clr) |=>
      ($changed(cfg_i) || clr || q == ($past(q) ^ $past(f_val))));

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> !q);

  // R10
  fb_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fbpin_m |-> (fb_o == q));

  // R2
  out_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comb_m |-> (out_o == q));
endmodule

bind pt_macrocell mc_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_i   (cfg_i),
  .q       (q),
  .f_val   (f_val),
  .clr     (pt_clr),
  .async_m (ctl[mc_pkg::C_ASYNC]),
  .neg_m   (ctl[mc_pkg::C_NEG]),
  .tff_m   (ctl[mc_pkg::C_TFF]),
  .comb_m  (ctl[mc_pkg::C_COMB]),
  .fbpin_m (ctl[mc_pkg::C_FBPIN]),
  .out_o   (out_o),
  .oe_o    (oe_o),
  .fb_o    (fb_o)
);

// File: tb/sim_pt_macrocell.sv
module sim_pt_macrocell;
  localparam int N_IN = 4;
  localparam int CFG_W = 20 * N_IN + 6;

  // ctl order: {fbpin, comb, async, neg, tff, inv}
  localparam logic [79:0] FZ_A = 80'h4000_0000_0000_0000_6005; // t0=i0&i1, t1=~i2&i3, t9=i3
  localparam logic [79:0] FZ_B = 80'h0000_0000_0000_00AA_0003; // t0=i0&~i0, t2=all inverted
  localparam logic [79:0] FZ_C = 80'h0000_4000_0000_0000_0000; // t7=i3
  localparam logic [79:0] FZ_D = 80'h4010_0000_0000_0000_6005; // A plus t8=i2

  typedef struct packed {
    logic [79:0] fz;
    logic [5:0]  ctl;
    logic [3:0]  in;
    logic        pad;
    logic        e_out;
    logic        e_oe;
    logic        e_fb;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{FZ_A, 6'b110000, 4'b0011, 1'b0, 1'b1, 1'b0, 1'b0},
    '{FZ_A, 6'b110000, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{FZ_A, 6'b110000, 4'b1100, 1'b0, 1'b0, 1'b1, 1'b0},
    '{FZ_A, 6'b110000, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b1},
    '{FZ_A, 6'b110001, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0},
    '{FZ_A, 6'b110001, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0},
    '{FZ_B, 6'b110000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0},
    '{FZ_B, 6'b110000, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0},
    '{FZ_C, 6'b110000, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b1},
    '{FZ_C, 6'b110000, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b0},
    '{FZ_A, 6'b111000, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b0},
    '{FZ_A, 6'b111000, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic [CFG_W-1:0] cfg_i = '0;
  logic pad_i = 1'b0;
  logic out_o, oe_o, fb_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pt_macrocell #(.N_IN(N_IN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in_i), .cfg_i(cfg_i),
    .pad_i(pad_i), .out_o(out_o), .oe_o(oe_o), .fb_o(fb_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [79:0] fz, input logic [5:0] ctl);
    @(negedge clk);
    rst_ni = 1'b0;
    in_i   = '0;
    cfg_i  = {ctl, fz};
    repeat (2) @(negedge clk);
    chk("R11 out in reset", out_o, 1'b0);
    chk("R11 fb in reset", fb_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    // reset state, registered output and register feedback
    do_reset(FZ_A, 6'b000000);

    // table: combinational path, polarity, oe, pin feedback
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfg_i = {TBL[i].ctl, TBL[i].fz};
      in_i  = TBL[i].in;
      pad_i = TBL[i].pad;
      #1;
      chk($sformatf("R1/R2/R3 row %0d out", i), out_o, TBL[i].e_out);
      chk($sformatf("R8/R9 row %0d oe", i), oe_o, TBL[i].e_oe);
      chk($sformatf("R10 row %0d fb", i), fb_o, TBL[i].e_fb);
    end

    // R4: D mode rising edge of global clock
    do_reset(FZ_A, 6'b000000);
    @(negedge clk); in_i = 4'b0011; #1;
    chk("R4 holds before edge", out_o, 1'b0);
    @(posedge clk); #1;
    chk("R4 loads on rising edge", out_o, 1'b1);
    chk("R10 fb shows register", fb_o, 1'b1);
    @(negedge clk); in_i = 4'b0000;
    @(posedge clk); #1;
    chk("R4 loads 0", out_o, 1'b0);

    // R5: falling edge
    @(negedge clk); cfg_i = {6'b000100, FZ_A}; in_i = 4'b0000;
    @(posedge clk); #1; in_i = 4'b0011; #1;
    chk("R5 no load on rising edge", out_o, 1'b0);
    @(negedge clk); #1;
    chk("R5 loads on falling edge", out_o, 1'b1);

    // R6: T mode
    do_reset(FZ_A, 6'b000010);
    @(negedge clk); in_i = 4'b0011;
    @(posedge clk); #1;
    chk("R6 toggle to 1", out_o, 1'b1);
    @(posedge clk); #1;
    chk("R6 toggle to 0", out_o, 1'b0);
    @(posedge clk); #1;
    chk("R6 toggle to 1 again", out_o, 1'b1);
    @(negedge clk); in_i = 4'b0000;
    @(posedge clk); #1;
    chk("R6 hold with sum 0", out_o, 1'b1);
    @(posedge clk); #1;
    chk("R6 still holds", out_o, 1'b1);

    // R11: reset acts without an edge
    @(negedge clk); rst_ni = 1'b0; #1;
    chk("R11 async reset", out_o, 1'b0);

    // R7: clear term
    do_reset(FZ_D, 6'b000000);
    @(negedge clk); in_i = 4'b0011;
    @(posedge clk); #1;
    chk("R7 setup load", out_o, 1'b1);
    @(negedge clk); in_i = 4'b0111; #1;
    chk("R7 clear without edge", out_o, 1'b0);
    @(posedge clk); #1;
    chk("R7 clear beats edge", out_o, 1'b0);
    @(negedge clk); in_i = 4'b0011;
    @(posedge clk); #1;
    chk("R7 loads after clear drops", out_o, 1'b1);

    // R8: local clock mode
    do_reset(FZ_A, 6'b001000);
    @(negedge clk); in_i = 4'b0011;
    @(posedge clk); #1;
    chk("R8 global clock ignored", out_o, 1'b0);
    chk("R8 oe forced with term 9 at 0", oe_o, 1'b1);
    @(negedge clk); in_i = 4'b1011; #1;
    chk("R8 loads on term 9 rise", out_o, 1'b1);
    @(negedge clk); in_i = 4'b1100;
    repeat (2) @(posedge clk); #1;
    chk("R8 holds across global edges", out_o, 1'b1);
    @(negedge clk); in_i = 4'b0100; #1;
    in_i = 4'b1100; #1;
    chk("R8 loads 0 on next term 9 rise", out_o, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule